// File: doc/BRIEF.md
# TDM Frame Sync Generator and Detector

This block handles the frame sync of a serial time-division multiplexed data port. In master mode it counts data clocks and drives a frame sync at every frame boundary. The pulse is either a single clock wide or a long pulse of exactly 8 clocks. The frame period is 512 clocks when the fast data clock rate is selected and 256 clocks at the slow rate, so both give an 8 kHz frame rate.

In slave mode the block drives no sync. It samples an incoming sync, finds each rising edge and measures how wide the pulse is, then reports whether the far end uses short or long framing. No configuration is needed for this. In both modes it emits a one-clock frame-start strobe for the downstream data shifters.

When timeslot assignment is active, long framing is not permitted. The master then falls back to a short pulse, and a flag reports the conflict in either mode.

Top module: `fsync_unit`

## Requirements
- R1: In master mode with long framing off, `fs_out` is high for exactly one clock per frame. The first pulse comes in the first cycle after reset is released, and later pulses follow every 256 clocks (`fast_rate`=0) or every 512 clocks (`fast_rate`=1).
- R2: In master mode with `long_req`=1 and `tsa_en`=0, `fs_out` rises at each frame start and stays high for 8 consecutive clocks.
- R3: The long pulse is 8 clocks wide at both frame rates.
- R4: In slave mode `fs_out` stays low. The block follows the framing style of `fs_in` whatever the values of `long_req` and `fast_rate` for framing type.
- R5: `frame_start` is a one-clock strobe. In master mode it coincides with the first high cycle of `fs_out`. In slave mode it is high in the cycle after the clock edge at which `fs_in` is first sampled high after being low.
- R6: In slave mode `long_det` updates in the cycle after a pulse on `fs_in` ends. It becomes 1 if the pulse was sampled high on 2 or more edges and 0 if on exactly one edge. It holds that value until the next pulse ends.
- R7: With `tsa_en`=1, a master with `long_req`=1 emits short pulses. `long_err` is 1 while `tsa_en`=1 and either (master and `long_req`=1) or (slave and `long_det`=1); otherwise it is 0.
- R8: In slave mode, `sync_err` pulses high for one clock when `fs_in` is still high at the edge exactly one frame period after the rising edge that began the frame.
- R9: While `rst_n` is low, `fs_out`, `frame_start`, `long_det` and `sync_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master | input | 1 | 1 = generate sync, 0 = follow `fs_in` |
| fast_rate | input | 1 | 1 = 512-clock frame, 0 = 256-clock frame |
| long_req | input | 1 | Master: request 8-clock long sync |
| tsa_en | input | 1 | Timeslot assignment active; long framing blocked |
| fs_in | input | 1 | Incoming frame sync (slave mode) |
| fs_out | output | 1 | Generated frame sync (master mode) |
| frame_start | output | 1 | One-clock frame boundary strobe |
| long_det | output | 1 | Framing type in effect: 1 = long, 0 = short |
| long_err | output | 1 | Long framing requested or seen while timeslot assignment is on |
| sync_err | output | 1 | Incoming sync still high at the next frame boundary |

## Verification
A wrong frame counter shows on `fs_out` or `sync_err` no later than one frame period, at most 512 clocks, because each output cycle is compared against the expected one. A stuck or wrongly cleared width flag shows on `long_det` in the cycle after the next incoming pulse ends. A wrong edge detector shows on `frame_start` in the cycle after the rise. Every cycle of every sweep is compared, so a fault cannot hide in the cycles between checks.

// File: rtl/fsync_unit.sv
module fsync_unit #(
  parameter int LONG_CLKS  = 8,
  parameter int SLOW_FRAME = 256,
  parameter int FAST_FRAME = 512,
  localparam int CW = $clog2(FAST_FRAME)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic fast_rate,
  input  logic long_req,
  input  logic tsa_en,
  input  logic fs_in,
  output logic fs_out,
  output logic frame_start,
  output logic long_det,
  output logic long_err,
  output logic sync_err
);

  logic [CW-1:0] cnt, cnt_n, last;
  logic fs_prev, wide, rise, long_eff, wrap;

  assign last     = fast_rate ? CW'(FAST_FRAME - 1) : CW'(SLOW_FRAME - 1);
  assign rise     = fs_in & ~fs_prev;
  assign long_eff = long_req & ~tsa_en;
  assign cnt_n    = ((!master && rise) || cnt >= last) ? '0 : cnt + 1'b1;
  assign wrap     = (cnt_n == '0);
  assign long_err = tsa_en & (master ? long_req : long_det);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '1;
      fs_prev     <= 1'b0;
      wide        <= 1'b0;
      fs_out      <= 1'b0;
      frame_start <= 1'b0;
      long_det    <= 1'b0;
      sync_err    <= 1'b0;
    end else begin
      cnt         <= cnt_n;
      fs_prev     <= fs_in;
      fs_out      <= master & (wrap | (long_eff & (cnt_n < CW'(LONG_CLKS))));
      frame_start <= master ? wrap : rise;
      sync_err    <= ~master & fs_in & fs_prev & wrap;
      if (rise)        wide <= 1'b0;
      else if (fs_in)  wide <= 1'b1;
      if (master)                 long_det <= long_eff;
      else if (~fs_in & fs_prev)  long_det <= wide;
    end
  end

endmodule

module fsync_unit_chk #(
  parameter int LIM = 8
) (
  input logic clk,
  input logic rst_n,
  input logic master,
  input logic fs_in,
  input logic fs_out,
  input logic frame_start,
  input logic sync_err
);

  logic       up;
  logic [4:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up  <= 1'b0;
      run <= '0;
    end else begin
      up  <= 1'b1;
      run <= fs_out ? ((run == 5'd31) ? run : run + 1'b1) : '0;
    end
  end

  a_r3_pulse_len_max: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 5'(LIM));

  a_r4_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !master && !$past(master)) |-> !fs_out);

  a_r5_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !master && fs_in && !$past(fs_in)) |=> frame_start);

  a_r2_start_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (up && master && $past(master) && frame_start) |-> fs_out);

  a_r8_err_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (up && sync_err) |-> $past(fs_in));

endmodule

bind fsync_unit fsync_unit_chk #(.LIM(LONG_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .fs_in(fs_in),
  .fs_out(fs_out), .frame_start(frame_start), .sync_err(sync_err)
);

// File: tb/fsync_unit_test.sv
module fsync_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b1, fast_rate = 1'b0, long_req = 1'b0, tsa_en = 1'b0, fs_in = 1'b0;
  logic fs_out, frame_start, long_det, long_err, sync_err;

  int vecs = 0, errs = 0, err_pulses = 0;
  int mc, mprev, mwide, mlong;
  bit e_fs, e_st, e_err;

  always #4 clk = ~clk;

  fsync_unit uut (
    .clk(clk), .rst_n(rst_n), .master(master), .fast_rate(fast_rate),
    .long_req(long_req), .tsa_en(tsa_en), .fs_in(fs_in), .fs_out(fs_out),
    .frame_start(frame_start), .long_det(long_det), .long_err(long_err),
    .sync_err(sync_err)
  );

  task automatic chk(string req, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fs_in = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 fs_out", fs_out, 1'b0);
    chk("R9 frame_start", frame_start, 1'b0);
    chk("R9 long_det", long_det, 1'b0);
    chk("R9 sync_err", sync_err, 1'b0);
    mc = 511; mprev = 0; mwide = 0; mlong = 0;
    rst_n = 1'b1;
  endtask

  task automatic step();
    int p, s, rise;
    @(posedge clk);
    p = fast_rate ? 512 : 256;
    s = fs_in;
    rise = s && !mprev;
    if (!master && rise) mc = 0;
    else mc = (mc >= p - 1) ? 0 : mc + 1;
    e_fs  = master && (mc == 0 || (long_req && !tsa_en && mc < 8));
    e_st  = master ? (mc == 0) : rise;
    e_err = !master && s && mprev && mc == 0;
    if (master) mlong = long_req && !tsa_en;
    else if (!s && mprev) mlong = mwide;
    if (rise) mwide = 0; else if (s) mwide = 1;
    mprev = s;
    @(negedge clk);
    if (sync_err) err_pulses++;
    chk(master ? "R1 R2 R3 R7 fs_out" : "R4 fs_out", fs_out, e_fs);
    chk("R5 frame_start", frame_start, e_st);
    chk("R8 sync_err", sync_err, e_err);
    if (!master) chk("R6 long_det", long_det, mlong[0]);
    chk("R7 long_err", long_err, tsa_en && (master ? long_req : mlong[0]));
  endtask

  initial begin
    #1_200_000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int cfg = 0; cfg < 8; cfg++) begin
      master = 1'b1; fast_rate = cfg[0]; long_req = cfg[1]; tsa_en = cfg[2];
      do_reset();
      for (int i = 0; i < 3 * (fast_rate ? 512 : 256) + 10; i++) step();
    end

    for (int r = 0; r < 2; r++) begin
      master = 1'b0; fast_rate = r[0]; long_req = 1'b1;
      do_reset();
      for (int w = 1; w <= 10; w++) begin
        tsa_en = w[0];
        fs_in = 1'b1;
        for (int i = 0; i < w; i++) step();
        fs_in = 1'b0;
        for (int i = 0; i < (fast_rate ? 512 : 256) - w; i++) step();
      end
    end

    master = 1'b0; fast_rate = 1'b0; tsa_en = 1'b0;
    do_reset();
    err_pulses = 0;
    for (int i = 0; i < 4; i++) step();
    fs_in = 1'b1;
    for (int i = 0; i < 256 + 3; i++) step();
    fs_in = 1'b0;
    for (int i = 0; i < 4; i++) step();
    chk("R8 one sync_err pulse", err_pulses == 1, 1'b1);
    chk("R6 long after stuck pulse", long_det, 1'b1);

    fs_in = 1'b1; step();
    fs_in = 1'b0;
    for (int i = 0; i < 3; i++) step();
    chk("R6 short after 1-clock pulse", long_det, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule